// File: doc/BRIEF.md
# Per-Channel Reference Pixel Offset Corrector

This block sits in the pixel path of a multi-channel image sensor readout. The array is split into vertical stripes, one per output channel. Each channel has its own analog offset, which shows up as a constant level added to every pixel of that stripe. A few rows at one edge of the frame are reference rows that do not respond to light. The block averages each channel's reference pixels and subtracts that average from every other pixel of the same channel. Each channel's level is removed on its own, not as one global dark value.

Pixels arrive as a stream. Each carries a channel index, a column within the channel's stripe, a row number, and an unsigned ADC code. Separate strobes mark frame start and frame end. A configuration input chooses the edge that holds the reference rows, and it is sampled at frame start. With the reference rows at the top, the mean is formed inside the current frame and used at once. With the reference rows at the bottom, the mean measured in the previous frame is used.

The result is a signed value one bit wider than the input, so a pixel below the offset gives a negative number. Reference pixels pass through unchanged and are flagged.

Top module: `refpix_offset_corr`

## Requirements
- R1: After reset, `outValid` and `meanReady` are 0, and every channel's stored mean is 0.
- R2: A pixel is a reference pixel when its row is below `REF_ROWS` (top placement) or at or above `ROWS-REF_ROWS` (bottom placement). A reference pixel leaves the block with its raw code zero-extended and `outRef`=1.
- R3: With top placement, a channel's mean is the sum of its `COLS*REF_ROWS` reference pixels of the current frame, shifted right by log2(`COLS*REF_ROWS`). It applies to every non-reference pixel of that channel that follows the channel's pixel at row `REF_ROWS-1`, column `COLS-1`.
- R4: Each channel's accumulation and mean are independent of the others, including when pixels of different channels are interleaved.
- R5: With bottom placement, non-reference pixels are corrected with the mean held from earlier frames. At frame end, a channel's mean is replaced only if its pixel at row `ROWS-1`, column `COLS-1` was seen in that frame.
- R6: A non-reference pixel's output is its code minus its channel mean, as a 17-bit two's-complement value; results below zero do not wrap.
- R7: `meanReady` is 1 exactly when every channel has held a complete mean since reset. It does not fall except through reset.
- R8: The placement input is taken only on a `frameStart` cycle; changes at other times have no effect on the frame in progress.
- R9: `frameStart` clears every accumulator, so a mean reflects only the reference pixels of one frame.
- R10: The 24-bit accumulators hold the full sum of a channel's reference pixels at maximum code without overflow; the mean of all-maximum-code references is exact.
- R11: Each valid input pixel produces one output pixel one clock later, carrying the same channel index. `outValid` is 0 on cycles that follow no valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refBottom | input | 1 | Reference-row placement: 0 top, 1 bottom; sampled at frameStart |
| frameStart | input | 1 | Frame start strobe (cycle with no pixel) |
| frameEnd | input | 1 | Frame end strobe (cycle with no pixel) |
| pixValid | input | 1 | Input pixel valid |
| pixChan | input | $clog2(NCH) | Channel index of the pixel |
| pixCol | input | $clog2(COLS) | Column within the channel stripe |
| pixRow | input | $clog2(ROWS) | Row of the pixel |
| pixData | input | DATA_W | Unsigned ADC code |
| outValid | output | 1 | Output pixel valid |
| outPix | output | DATA_W+1 | Corrected signed pixel, or raw code for a reference pixel |
| outRef | output | 1 | Output pixel is a reference pixel |
| outChan | output | $clog2(NCH) | Channel index of the output pixel |
| meanReady | output | 1 | Every channel has a complete mean |

## Verification
The hardest case to reach from the ports is a bottom-placement frame whose reference region is cut short. In that case the held means must survive frame end untouched. The bench ends a frame one row early and then checks, in the next frame, that the outputs are still corrected with the means from two frames back.

Mode sampling is reached by flipping the placement input just after frame start and checking that the whole frame keeps the old region. Channels are interleaved pixel by pixel, each with its own offset, so a mean applied to the wrong channel shows up as an output error.

// File: rtl/offcorr_pkg.sv
package offcorr_pkg;

  typedef enum logic {
    PLACE_TOP    = 1'b0,
    PLACE_BOTTOM = 1'b1
  } refPlace_e;

  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic clearAll;    // frame start: wipe accumulators
    logic accumulate;  // valid reference pixel to add
    logic refPixel;    // current pixel lies in the reference region
    logic latchCur;    // top placement: last reference pixel, take mean now
    logic markDone;    // last reference pixel of a channel seen
    logic latchFrame;  // bottom placement: frame end, take completed means
  } refoffStrobes_t;

endpackage

// File: rtl/offcorr_ctrl.sv
module offcorr_ctrl
  import offcorr_pkg::*;
#(
  parameter int COLS     = 64,
  parameter int ROWS     = 2048,
  parameter int REF_ROWS = 4,
  localparam int COL_W   = $clog2(COLS),
  localparam int ROW_W   = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refBottom,
  input  logic             frameStart,
  input  logic             frameEnd,
  input  logic             pixValid,
  input  logic [COL_W-1:0] pixCol,
  input  logic [ROW_W-1:0] pixRow,
  output refoffStrobes_t   strobes
);

  refPlace_e placeMode;
  logic inRef;
  logic lastRef;
  logic [ROW_W-1:0] finalRefRow;

  always_ff @(posedge clk) begin
    if (rst) begin
      placeMode <= PLACE_TOP;
    end else if (frameStart) begin
      placeMode <= refBottom ? PLACE_BOTTOM : PLACE_TOP;
    end
  end

  always_comb begin
    if (placeMode == PLACE_BOTTOM) begin
      inRef       = (pixRow >= ROW_W'(ROWS - REF_ROWS));
      finalRefRow = ROW_W'(ROWS - 1);
    end else begin
      inRef       = (pixRow < ROW_W'(REF_ROWS));
      finalRefRow = ROW_W'(REF_ROWS - 1);
    end
    lastRef = inRef && (pixRow == finalRefRow) && (pixCol == COL_W'(COLS - 1));
  end

  always_comb begin
    strobes            = '0;
    strobes.clearAll   = frameStart;
    strobes.refPixel   = inRef;
    strobes.accumulate = pixValid && inRef;
    strobes.markDone   = pixValid && lastRef;
    strobes.latchCur   = pixValid && lastRef && (placeMode == PLACE_TOP);
    strobes.latchFrame = frameEnd && (placeMode == PLACE_BOTTOM);
  end

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frameStart |=> $stable(placeMode));

  // R5
  frame_latch_mode_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.latchFrame |-> !strobes.latchCur);

endmodule

// File: rtl/offcorr_datapath.sv
module offcorr_datapath
  import offcorr_pkg::*;
#(
  parameter int NCH      = 32,
  parameter int COLS     = 64,
  parameter int REF_ROWS = 4,
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 24,
  localparam int CH_W    = $clog2(NCH),
  localparam int REF_N   = COLS * REF_ROWS,
  localparam int SHIFT   = $clog2(REF_N)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  refoffStrobes_t           strobes,
  input  logic                     pixValid,
  input  logic [CH_W-1:0]          pixChan,
  input  logic [DATA_W-1:0]        pixData,
  output logic                     outValid,
  output logic signed [DATA_W:0]   outPix,
  output logic                     outRef,
  output logic [CH_W-1:0]          outChan,
  output logic                     meanReady
);

  logic [NCH-1:0][DATA_W-1:0] meanArr;
  logic [NCH-1:0]             haveMean;

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    logic [ACC_W-1:0]  acc;
    logic [ACC_W:0]    accNext;
    logic [DATA_W-1:0] meanR;
    logic              refDone;
    logic              hm;
    logic              hit;

    assign hit     = strobes.accumulate && (pixChan == CH_W'(g));
    assign accNext = {1'b0, acc} + (ACC_W + 1)'(pixData);

    always_ff @(posedge clk) begin
      if (rst) begin
        acc     <= '0;
        refDone <= 1'b0;
        meanR   <= '0;
        hm      <= 1'b0;
      end else begin
        if (strobes.clearAll) begin
          acc     <= '0;
          refDone <= 1'b0;
        end else if (hit) begin
          acc <= accNext[ACC_W-1:0];
          if (strobes.markDone) refDone <= 1'b1;
        end
        if (hit && strobes.latchCur) begin
          meanR <= accNext[SHIFT +: DATA_W];
          hm    <= 1'b1;
        end else if (strobes.latchFrame && refDone) begin
          meanR <= acc[SHIFT +: DATA_W];
          hm    <= 1'b1;
        end
      end
    end

    assign meanArr[g]  = meanR;
    assign haveMean[g] = hm;

    // R9
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
      strobes.clearAll |=> (acc == '0));

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
      hit |-> !accNext[ACC_W]);
  end

  logic [DATA_W-1:0]      meanCur;
  logic signed [DATA_W:0] diff;

  assign meanCur = meanArr[pixChan];
  assign diff    = $signed({1'b0, pixData}) - $signed({1'b0, meanCur});

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outPix   <= '0;
      outRef   <= 1'b0;
      outChan  <= '0;
    end else begin
      outValid <= pixValid;
      if (pixValid) begin
        outPix  <= strobes.refPixel ? $signed({1'b0, pixData}) : diff;
        outRef  <= strobes.refPixel;
        outChan <= pixChan;
      end
    end
  end

  assign meanReady = &haveMean;

  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !$fell(meanReady));

  // R2
  ref_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outRef) |-> (outPix == $signed({1'b0, $past(pixData)})));

  // R11
  out_chan_chk: assert property (@(posedge clk) disable iff (rst)
    $past(pixValid) |-> (outChan == $past(pixChan)));

endmodule

// File: rtl/refpix_offset_corr.sv
module refpix_offset_corr
  import offcorr_pkg::*;
#(
  parameter int NCH      = 32,
  parameter int COLS     = 64,
  parameter int ROWS     = 2048,
  parameter int REF_ROWS = 4,
  parameter int DATA_W   = 16,
  parameter int ACC_W    = 24,
  localparam int CH_W    = $clog2(NCH),
  localparam int COL_W   = $clog2(COLS),
  localparam int ROW_W   = $clog2(ROWS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   refBottom,
  input  logic                   frameStart,
  input  logic                   frameEnd,
  input  logic                   pixValid,
  input  logic [CH_W-1:0]        pixChan,
  input  logic [COL_W-1:0]       pixCol,
  input  logic [ROW_W-1:0]       pixRow,
  input  logic [DATA_W-1:0]      pixData,
  output logic                   outValid,
  output logic signed [DATA_W:0] outPix,
  output logic                   outRef,
  output logic [CH_W-1:0]        outChan,
  output logic                   meanReady
);

  refoffStrobes_t strobes;

  offcorr_ctrl #(
    .COLS     (COLS),
    .ROWS     (ROWS),
    .REF_ROWS (REF_ROWS)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .refBottom  (refBottom),
    .frameStart (frameStart),
    .frameEnd   (frameEnd),
    .pixValid   (pixValid),
    .pixCol     (pixCol),
    .pixRow     (pixRow),
    .strobes    (strobes)
  );

  offcorr_datapath #(
    .NCH      (NCH),
    .COLS     (COLS),
    .REF_ROWS (REF_ROWS),
    .DATA_W   (DATA_W),
    .ACC_W    (ACC_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .pixValid  (pixValid),
    .pixChan   (pixChan),
    .pixData   (pixData),
    .outValid  (outValid),
    .outPix    (outPix),
    .outRef    (outRef),
    .outChan   (outChan),
    .meanReady (meanReady)
  );

endmodule

// File: tb/refpix_offset_corr_bench.sv
`timescale 1ns/1ps
module refpix_offset_corr_bench;

  localparam int NCH = 4, COLS = 8, ROWS = 8, REF_ROWS = 4, DATA_W = 16, ACC_W = 24;

  logic clk = 1'b0;
  logic rst, refBottom, frameStart, frameEnd, pixValid;
  logic [1:0] pixChan;
  logic [2:0] pixCol, pixRow;
  logic [15:0] pixData;
  logic outValid, outRef, meanReady;
  logic signed [16:0] outPix;
  logic [1:0] outChan;

  int errors = 0;
  int checks = 0;
  int refBase[NCH];
  int actBase[NCH];
  int curMean[NCH];
  bit readyExp;

  always #4 clk = ~clk;

  refpix_offset_corr #(
    .NCH(NCH), .COLS(COLS), .ROWS(ROWS), .REF_ROWS(REF_ROWS),
    .DATA_W(DATA_W), .ACC_W(ACC_W)
  ) u_refpix_offset_corr (
    .clk(clk), .rst(rst), .refBottom(refBottom), .frameStart(frameStart),
    .frameEnd(frameEnd), .pixValid(pixValid), .pixChan(pixChan), .pixCol(pixCol),
    .pixRow(pixRow), .pixData(pixData), .outValid(outValid), .outPix(outPix),
    .outRef(outRef), .outChan(outChan), .meanReady(meanReady)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; refBottom = 1'b0; frameStart = 1'b0; frameEnd = 1'b0;
    pixValid = 1'b0; pixChan = '0; pixCol = '0; pixRow = '0; pixData = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    readyExp = 1'b0;
    for (int c = 0; c < NCH; c++) curMean[c] = 0;
    check(outValid == 1'b0, "R1 outValid after reset", int'(outValid), 0);
    check(meanReady == 1'b0, "R1 meanReady after reset", int'(meanReady), 0);
  endtask

  task automatic sendPix(input int ch, input int col, input int row, input int data,
                         input bit isRef, input string tag);
    int exp;
    @(negedge clk);
    pixValid = 1'b1; pixChan = 2'(ch); pixCol = 3'(col); pixRow = 3'(row);
    pixData = 16'(data);
    @(posedge clk);
    #1;
    exp = isRef ? data : data - curMean[ch];
    check(outValid && (outRef == isRef) && (outChan == 2'(ch)) && (int'(outPix) == exp),
          $sformatf("%s ch%0d r%0d c%0d ref=%0d", tag, ch, row, col, isRef),
          int'(outPix), exp);
  endtask

  // one frame; stream rows 0..lastRow with channels interleaved per column
  task automatic doFrame(input bit bot, input bit flip, input int lastRow, input string tag);
    bit isRef;
    int data;
    @(negedge clk);
    refBottom = bot; frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
    if (flip) refBottom = !bot;
    if (!bot) for (int c = 0; c < NCH; c++) curMean[c] = refBase[c] + 1;
    for (int r = 0; r <= lastRow; r++)
      for (int col = 0; col < COLS; col++)
        for (int c = 0; c < NCH; c++) begin
          isRef = bot ? (r >= ROWS - REF_ROWS) : (r < REF_ROWS);
          data  = isRef ? refBase[c] + 2 * (col % 2) : actBase[c] + 3 * col + r;
          sendPix(c, col, r, data, isRef, isRef ? "R2 R11" : tag);
        end
    if (!bot) readyExp = 1'b1;
    @(negedge clk);
    pixValid = 1'b0;
    check(meanReady == readyExp, "R7 meanReady before frame end", int'(meanReady), int'(readyExp));
    frameEnd = 1'b1;
    @(negedge clk);
    frameEnd = 1'b0;
    if (bot && lastRow == ROWS - 1) begin
      for (int c = 0; c < NCH; c++) curMean[c] = refBase[c] + 1;
      readyExp = 1'b1;
    end
    check(outValid == 1'b0, "R11 idle output", int'(outValid), 0);
    check(meanReady == readyExp, "R7 meanReady after frame end", int'(meanReady), int'(readyExp));
  endtask

  task automatic testTopBasic();
    refBase = '{1000, 4000, 20000, 300};
    actBase = '{1500, 3000, 20500, 0};
    doFrame(1'b0, 1'b1, ROWS - 1, "R3 R4 R6 R8");
  endtask

  task automatic testTopReframe();
    refBase = '{7000, 100, 50000, 2222};
    actBase = '{7100, 50, 60000, 2300};
    doFrame(1'b0, 1'b0, ROWS - 1, "R9 R3");
  endtask

  task automatic testTopFullScale();
    refBase = '{65533, 65533, 65533, 65533};
    actBase = '{0, 0, 0, 0};
    doFrame(1'b0, 1'b0, ROWS - 1, "R10 R6");
  endtask

  task automatic testBottomSequence();
    doReset();
    refBase = '{900, 1800, 2700, 3600};
    actBase = '{1000, 2000, 3000, 4000};
    doFrame(1'b1, 1'b0, ROWS - 1, "R5 first frame");
    refBase = '{5000, 6000, 7000, 8000};
    actBase = '{100, 6100, 6900, 9000};
    doFrame(1'b1, 1'b1, ROWS - 1, "R5 R4 R6 R8");
    refBase = '{30000, 31000, 32000, 33000};
    actBase = '{500, 600, 700, 800};
    doFrame(1'b1, 1'b0, ROWS - 2, "R5 truncated");
    refBase = '{12, 13, 14, 15};
    actBase = '{40000, 100, 5000, 7990};
    doFrame(1'b1, 1'b0, ROWS - 1, "R5 after truncated");
  endtask

  initial begin
    rst = 1'b1;
    doReset();
    testTopBasic();
    testTopReframe();
    testTopFullScale();
    testBottomSequence();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule